// File: doc/BRIEF.md
# Single-Cycle 8-Bit Teaching Processor

This block is a small processor with separate code and data memories. It retires one 16-bit instruction on every clock edge where the enable input is high, and holds all of its state when the enable is low. It has four 8-bit general registers, a 16-word by 8-bit data memory, and a read-only code store. The code store and the data memory get their contents from parameter arrays when the design is elaborated.

The instruction set is small: immediate load, add-immediate, register subtract, direct and register-indexed loads, an indexed store, compare, an unconditional PC-relative jump, and a conditional branch on signed greater-or-equal. Read-only taps expose the program counter, all four registers and the lowest data words, so a display or a bench can follow execution without any other access path.

Top module: `cpu8_core`

## Requirements
- R1: While `rst_ni` is low, the program counter and all four registers are zero. Reset acts at once, without waiting for a clock edge. Data memory keeps its contents through reset and is loaded from `DATA_INIT` only at elaboration.
- R2: An instruction splits into the opcode in bits 15:12, the first register (`ra`) in bits 11:10, the second register or condition (`rb`) in bits 9:8, and an 8-bit constant `k` in bits 7:0. Register codes are 0 to 3, for registers A to D. The opcodes are 0x0 no-op, 0x3 load-immediate, 0x5 add-immediate, 0x6 subtract, 0x8 direct load, 0x9 indexed load, 0xB indexed store, 0xD compare, 0xE jump and 0xF branch.
- R3: Load-immediate writes `k` into `ra`.
- R4: Add-immediate writes `ra + k` into `ra`. Subtract writes `ra - rb` into `ra`. Both set the negative flag (bit 7 of the result) and the signed-overflow flag.
- R5: Compare sets the same two flags from `ra - rb` and writes no register. A branch whose `rb` field is 3 goes to `PC + 1 + sext(k)` when the negative flag equals the overflow flag (signed greater-or-equal). Any other `rb` field value never branches.
- R6: Direct load reads data word `k[3:0]`. Indexed load reads word `(k + rb) mod 256`, keeping the low 4 bits. The word read is written into `ra`.
- R7: Indexed store writes `ra` to data word `((k + rb) mod 256)[3:0]`.
- R8: Jump sets the PC to `PC + 1 + sext(k)`, modulo 256.
- R9: The no-op and every unassigned opcode only advance the PC by one. A fetch from an address at or beyond `CODE_DEPTH` returns a no-op.
- R10: With `en_i` low, a clock edge changes neither the PC, nor the registers, nor the data memory.
- R11: `reg_tap_o[i]` is the register with code `i`. `dmem_tap_o[i]` is data word `i`.
- R12: The bubble-sort program run on the array 7,3,2,1,6,4,5,8 leaves words 0 to 7 holding 1 to 8 by the time the PC reaches 19, the address of its final no-op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Step enable; one instruction per enabled edge |
| pc_o | output | 8 | Program counter tap |
| reg_tap_o | output | 4x8 | Register taps, indexed by register code |
| dmem_tap_o | output | TAP_WORDSx8 | Taps of data words 0 to TAP_WORDS-1 |

## Verification
The bench goes after the signed corners of the flags. One case is an add that overflows from 0x7F to 0x80 and must still count as greater-or-equal. Another is a compare of 5 against -128 whose subtraction overflows. A design that used unsigned or negative-only tests would branch the wrong way at those points and run instructions the program skips. Index sums that pass 255 and 15 check that the data address wraps. A wrong wrap sends stores and loads to the wrong word, and the data taps show it. Random enable gaps, a backward self-jump and a mid-run reset catch a design that advances while disabled, that gets the sign of its offsets wrong, or that clears memory on reset.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int DATA_W  = 8;
  localparam int PC_W    = 8;
  localparam int INSTR_W = 16;
  localparam int NREG    = 4;
  localparam int RAW     = $clog2(NREG);

  typedef enum logic [3:0] {
    OP_NOOP = 4'h0,
    OP_LDI  = 4'h3,
    OP_ADDI = 4'h5,
    OP_SUB  = 4'h6,
    OP_LD   = 4'h8,
    OP_LDX  = 4'h9,
    OP_STX  = 4'hB,
    OP_CMP  = 4'hD,
    OP_JMP  = 4'hE,
    OP_BR   = 4'hF
  } op_e;

  localparam logic [1:0] COND_GE = 2'b11;

  typedef enum logic [1:0] {WB_IMM, WB_ALU, WB_MEM} wb_sel_e;

  typedef struct packed {
    logic n;
    logic v;
  } flags_t;

  typedef struct packed {
    logic    rf_we;
    wb_sel_e wb_sel;
    logic    flags_we;
    logic    alu_sub;
    logic    alu_b_imm;
    logic    mem_we;
    logic    mem_idx;
    logic    jump;
    logic    branch;
  } ctrl_t;
endpackage

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] y_o,
  output flags_t       flags_o
);
  logic [W-1:0] b_eff;
  logic         sign_clash;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    y_o   = a_i + b_eff + W'(sub_i);
    // overflow when operands agree in sign (after inversion) and result does not
    sign_clash = (a_i[W-1] == b_eff[W-1]) && (y_o[W-1] != a_i[W-1]);
    flags_o.n = y_o[W-1];
    flags_o.v = sign_clash;
  end
endmodule

// File: rtl/cpu8_decode.sv
module cpu8_decode
  import cpu8_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output ctrl_t              ctrl_o,
  output logic [RAW-1:0]     ra_o,
  output logic [RAW-1:0]     rb_o,
  output logic [DATA_W-1:0]  imm_o
);
  logic [3:0] op;

  assign op    = instr_i[15:12];
  assign ra_o  = instr_i[11:10];
  assign rb_o  = instr_i[9:8];
  assign imm_o = instr_i[7:0];

  always_comb begin
    ctrl_o = '0;
    ctrl_o.wb_sel = WB_IMM;
    case (op)
      OP_LDI: ctrl_o.rf_we = 1'b1;
      OP_ADDI: begin
        ctrl_o.rf_we     = 1'b1;
        ctrl_o.wb_sel    = WB_ALU;
        ctrl_o.flags_we  = 1'b1;
        ctrl_o.alu_b_imm = 1'b1;
      end
      OP_SUB: begin
        ctrl_o.rf_we    = 1'b1;
        ctrl_o.wb_sel   = WB_ALU;
        ctrl_o.flags_we = 1'b1;
        ctrl_o.alu_sub  = 1'b1;
      end
      OP_CMP: begin
        ctrl_o.flags_we = 1'b1;
        ctrl_o.alu_sub  = 1'b1;
      end
      OP_LD: begin
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.wb_sel = WB_MEM;
      end
      OP_LDX: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.wb_sel  = WB_MEM;
        ctrl_o.mem_idx = 1'b1;
      end
      OP_STX: begin
        ctrl_o.mem_we  = 1'b1;
        ctrl_o.mem_idx = 1'b1;
      end
      OP_JMP: ctrl_o.jump = 1'b1;
      OP_BR:  ctrl_o.branch = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile
  import cpu8_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int N = NREG,
  localparam int AW = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       waddr_i,
  input  logic [W-1:0]        wdata_i,
  input  logic [AW-1:0]       raddr_a_i,
  input  logic [AW-1:0]       raddr_b_i,
  output logic [W-1:0]        rdata_a_o,
  output logic [W-1:0]        rdata_b_o,
  output logic [N-1:0][W-1:0] tap_o
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r_q <= '0;
      else if (we_i && waddr_i == AW'(g)) r_q <= wdata_i;
    end
    assign tap_o[g] = r_q;
  end

  assign rdata_a_o = tap_o[raddr_a_i];
  assign rdata_b_o = tap_o[raddr_b_i];
endmodule

// File: rtl/cpu8_dmem.sv
module cpu8_dmem
  import cpu8_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int DEPTH = 16,
  parameter int TAPS  = 8,
  parameter logic [W-1:0] INIT [DEPTH] = '{default: '0},
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [W-1:0]           wdata_i,
  output logic [W-1:0]           rdata_o,
  output logic [TAPS-1:0][W-1:0] tap_o
);
  logic [W-1:0] mem [DEPTH];

  // contents come from INIT at configuration only; reset leaves them alone
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT[i];
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign tap_o[g] = mem[g];
  end
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int CODE_DEPTH = 32,
  parameter int DMEM_DEPTH = 16,
  parameter int TAP_WORDS  = 8,
  parameter logic [INSTR_W-1:0] CODE_INIT [CODE_DEPTH] = '{default: '0},
  parameter logic [DATA_W-1:0]  DATA_INIT [DMEM_DEPTH] = '{default: '0}
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             en_i,
  output logic [PC_W-1:0]                  pc_o,
  output logic [NREG-1:0][DATA_W-1:0]      reg_tap_o,
  output logic [TAP_WORDS-1:0][DATA_W-1:0] dmem_tap_o
);
  localparam int CAW = $clog2(CODE_DEPTH);
  localparam int DAW = $clog2(DMEM_DEPTH);

  logic [PC_W-1:0]    pc_q, pc_next;
  logic [INSTR_W-1:0] instr;
  ctrl_t              ctrl;
  logic [RAW-1:0]     ra, rb;
  logic [DATA_W-1:0]  imm;
  logic [DATA_W-1:0]  rdata_a, rdata_b, alu_b, alu_y, mem_rdata, wb_data;
  logic [DAW-1:0]     maddr;
  flags_t             flags_q, alu_flags;
  logic               taken;

  // fetch; past the end of the code store reads as a no-op
  always_comb begin
    instr = '0;
    if ({1'b0, pc_q} < (PC_W + 1)'(CODE_DEPTH)) instr = CODE_INIT[pc_q[CAW-1:0]];
  end

  cpu8_decode u_dec (
    .instr_i(instr),
    .ctrl_o (ctrl),
    .ra_o   (ra),
    .rb_o   (rb),
    .imm_o  (imm)
  );

  cpu8_regfile u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (en_i && ctrl.rf_we),
    .waddr_i  (ra),
    .wdata_i  (wb_data),
    .raddr_a_i(ra),
    .raddr_b_i(rb),
    .rdata_a_o(rdata_a),
    .rdata_b_o(rdata_b),
    .tap_o    (reg_tap_o)
  );

  assign alu_b = ctrl.alu_b_imm ? imm : rdata_b;

  cpu8_alu u_alu (
    .a_i    (rdata_a),
    .b_i    (alu_b),
    .sub_i  (ctrl.alu_sub),
    .y_o    (alu_y),
    .flags_o(alu_flags)
  );

  // 8-bit sum, then the low bits select the word
  assign maddr = DAW'(imm + (ctrl.mem_idx ? rdata_b : '0));

  cpu8_dmem #(
    .DEPTH(DMEM_DEPTH),
    .TAPS (TAP_WORDS),
    .INIT (DATA_INIT)
  ) u_dmem (
    .clk_i  (clk_i),
    .we_i   (en_i && ctrl.mem_we),
    .addr_i (maddr),
    .wdata_i(rdata_a),
    .rdata_o(mem_rdata),
    .tap_o  (dmem_tap_o)
  );

  always_comb begin
    case (ctrl.wb_sel)
      WB_ALU:  wb_data = alu_y;
      WB_MEM:  wb_data = mem_rdata;
      default: wb_data = imm;
    endcase
  end

  assign taken   = ctrl.jump || (ctrl.branch && rb == COND_GE && flags_q.n == flags_q.v);
  assign pc_next = taken ? pc_q + PC_W'(1) + imm : pc_q + PC_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      flags_q <= '0;
    end else if (en_i) begin
      pc_q <= pc_next;
      if (ctrl.flags_we) flags_q <= alu_flags;
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk
  import cpu8_pkg::*;
#(
  parameter int TAPS = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        en_i,
  input logic [INSTR_W-1:0]          instr_i,
  input logic [PC_W-1:0]             pc_i,
  input logic [NREG-1:0][DATA_W-1:0] regs_i,
  input logic [TAPS-1:0][DATA_W-1:0] dtap_i
);
  logic [3:0] op;
  assign op = instr_i[15:12];

  // R1
  rst_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_i == '0 && regs_i == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(pc_i) && $stable(regs_i) && $stable(dtap_i)));

  // R3
  ldi_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == OP_LDI) |=> regs_i[$past(instr_i[11:10])] == $past(instr_i[7:0]));

  // R5
  cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == OP_CMP) |=> ($stable(regs_i) && $stable(dtap_i) && pc_i == $past(pc_i) + 8'd1));

  // R8
  jump_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == OP_JMP) |=> pc_i == $past(pc_i) + 8'd1 + $past(instr_i[7:0]));

  // R9
  noop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == OP_NOOP) |=> ($stable(regs_i) && pc_i == $past(pc_i) + 8'd1));
endmodule

bind cpu8_core cpu8_core_chk #(.TAPS(TAP_WORDS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .instr_i(instr),
  .pc_i   (pc_q),
  .regs_i (reg_tap_o),
  .dtap_i (dmem_tap_o)
);

// File: tb/sim_cpu8_core.sv
module sim_cpu8_core;
  localparam logic [15:0] SORT_CODE [32] = '{
    16'h3000, 16'h8C08, 16'h3400, 16'hD300, 16'hF30E, 16'h8C08, 16'h6C00, 16'hD700,
    16'hF308, 16'h9900, 16'h9D01, 16'hDE00, 16'hF302, 16'hBD00, 16'hB901, 16'h5401,
    16'hE0F4, 16'h5001, 16'hE0EE, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
    16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
  localparam logic [7:0] SORT_DATA [16] = '{
    8'd7, 8'd3, 8'd2, 8'd1, 8'd6, 8'd4, 8'd5, 8'd8,
    8'd7, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0};
  // directed corners: add overflow, signed compare, wrap of index sums, odd opcodes
  localparam logic [15:0] DIR_CODE [32] = '{
    16'h307F, 16'h5001, 16'hF301, 16'h3CEE, 16'h3405, 16'hD400, 16'hF301, 16'h3C11,
    16'hD100, 16'hF301, 16'h380F, 16'h3403, 16'hB90E, 16'h9DFF, 16'h8801, 16'h6E00,
    16'h2FFF, 16'hF003, 16'hE0FF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
    16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
  localparam logic [7:0] DIR_DATA [16] = '{
    8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65, 8'h76, 8'h87,
    8'h98, 8'hA9, 8'hBA, 8'hCB, 8'hDC, 8'hED, 8'hFE, 8'h0F};

  typedef struct packed {
    logic [7:0]       pc;
    logic [3:0][7:0]  r;
    logic [15:0][7:0] m;
    logic             n;
    logic             v;
  } st_t;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic en = 1'b0;
  logic [7:0] pc0, pc1;
  logic [3:0][7:0] rg0, rg1;
  logic [7:0][7:0] dm0, dm1;
  int checks = 0;
  int errors = 0;
  st_t s0, s1;
  logic en_prev = 1'b0;
  logic sorted_seen = 1'b0;

  always #5 clk = ~clk;

  cpu8_core #(.CODE_INIT(SORT_CODE), .DATA_INIT(SORT_DATA)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pc_o(pc0), .reg_tap_o(rg0), .dmem_tap_o(dm0));
  cpu8_core #(.CODE_INIT(DIR_CODE), .DATA_INIT(DIR_DATA)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pc_o(pc1), .reg_tap_o(rg1), .dmem_tap_o(dm1));

  function automatic logic [15:0] fetch(input logic [15:0] code [32], input logic [7:0] pc);
    return (pc < 8'd32) ? code[pc[4:0]] : 16'h0000;
  endfunction

  // reference step, written from the requirements (field split per R2)
  function automatic st_t step(input st_t s, input logic [15:0] ins);
    st_t t;
    logic [3:0] op;
    logic [1:0] a, b;
    logic [7:0] k, res, x, y;
    t = s; op = ins[15:12]; a = ins[11:10]; b = ins[9:8]; k = ins[7:0];
    t.pc = s.pc + 8'd1;
    x = s.r[a];
    case (op)
      4'h3: t.r[a] = k;
      4'h5: begin
        res = x + k; t.r[a] = res; t.n = res[7];
        t.v = (x[7] == k[7]) && (res[7] != x[7]);
      end
      4'h6, 4'hD: begin
        y = s.r[b]; res = x - y; t.n = res[7];
        t.v = (x[7] != y[7]) && (res[7] != x[7]);
        if (op == 4'h6) t.r[a] = res;
      end
      4'h8: t.r[a] = s.m[k[3:0]];
      4'h9: t.r[a] = s.m[4'(k + s.r[b])];
      4'hB: t.m[4'(k + s.r[b])] = x;
      4'hE: t.pc = s.pc + 8'd1 + k;
      4'hF: if (b == 2'b11 && s.n == s.v) t.pc = s.pc + 8'd1 + k;
      default: ;
    endcase
    return t;
  endfunction

  function automatic string tag_of(input logic was_en, input logic [15:0] ins);
    if (!was_en) return "R10";
    case (ins[15:12])
      4'h3: return "R3 (R2 fields)";
      4'h5, 4'h6: return "R4";
      4'hD, 4'hF: return "R5";
      4'h8, 4'h9: return "R6";
      4'hB: return "R7";
      4'hE: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic st_t init_st(input logic [7:0] d [16]);
    st_t t;
    t = '0;
    for (int i = 0; i < 16; i++) t.m[i] = d[i];
    return t;
  endfunction

  task automatic run(input int cycles);
    string t0, t1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      t0 = tag_of(en_prev, fetch(SORT_CODE, s0.pc));
      t1 = tag_of(en_prev, fetch(DIR_CODE, s1.pc));
      if (en_prev) begin
        s0 = step(s0, fetch(SORT_CODE, s0.pc));
        s1 = step(s1, fetch(DIR_CODE, s1.pc));
      end
      chk({t0, " pc"}, 64'(pc0), 64'(s0.pc));
      chk({t0, " regs (R11)"}, 64'(rg0), 64'(s0.r));
      chk({t0, " dmem"}, dm0, s0.m[7:0]);
      chk({t1, " pc"}, 64'(pc1), 64'(s1.pc));
      chk({t1, " regs (R11)"}, 64'(rg1), 64'(s1.r));
      chk({t1, " dmem"}, dm1, s1.m[7:0]);
      if (pc0 == 8'd19 && !sorted_seen) begin
        sorted_seen = 1'b1;
        for (int i = 0; i < 8; i++) chk("R12 sorted word", 64'(dm0[i]), 64'(i + 1));
      end
      en = c < 24 ? 1'b1 : (($urandom % 4) != 0);
      en_prev = en;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1 / R11: reset state and initial memory image
    chk("R1 pc reset", 64'(pc0), 64'd0);
    chk("R1 regs reset", 64'(rg0), 64'd0);
    chk("R1 pc reset", 64'(pc1), 64'd0);
    chk("R1 regs reset", 64'(rg1), 64'd0);
    for (int i = 0; i < 8; i++) begin
      chk("R11 init tap", 64'(dm0[i]), 64'(SORT_DATA[i]));
      chk("R11 init tap", 64'(dm1[i]), 64'(DIR_DATA[i]));
    end
    rst_n = 1'b1;
    s0 = init_st(SORT_DATA);
    s1 = init_st(DIR_DATA);
    run(1500);
    chk("R12 final no-op reached", 64'(sorted_seen), 64'd1);
    // mid-run reset: immediate clear, memory kept
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async pc clear", 64'(pc0), 64'd0);
    chk("R1 async regs clear", 64'(rg1), 64'd0);
    chk("R1 memory kept", dm0, s0.m[7:0]);
    chk("R1 memory kept", dm1, s1.m[7:0]);
    s0.pc = '0; s0.r = '0; s0.n = 1'b0; s0.v = 1'b0;
    s1.pc = '0; s1.r = '0; s1.n = 1'b0; s1.v = 1'b0;
    en = 1'b0; en_prev = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run(800);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule